// File: doc/BRIEF.md
# Parallel-to-Serial Shift Converter

This block takes a parallel word from an upstream producer and sends it out as a serial stream, several bits per shift step. It suits the transmit side of an SPI-style master. The producer offers a word on `load_i` together with a bit count (`size_i`) and a bit-order select (`lsb_first_i`). A shift-clock generator outside the block pulses `shift_i` once for each step. The block shows the current step on `ser_o` and raises `access_o` while those bits are valid. It holds `stall_o` high for the whole transfer, so the producer knows when its next offer will be taken.

Control is a two-state machine. `ST_IDLE` waits for a word. The transition ACCEPT (a load with a non-zero effective size, taken in `ST_IDLE`) moves it to `ST_SEND`. `ST_SEND` presents one step per cycle. It advances on each `shift_i` and stays put when there is none (transition HOLD). The transition FINISH is taken on the shift that uses up the remaining-bit counter, and it returns the machine to `ST_IDLE`. Any load offered in `ST_SEND` is refused.

When a load is accepted, the word is aligned in the shift register so that only its low `size` bits leave the block. Step positions past the last valid bit read zero.

Top module: `pser_shifter`

## Requirements
- R1: After reset, `access_o`, `stall_o` and `ser_o` are all 0.
- R2: In `ST_IDLE`, a load with a non-zero effective size is accepted at the clock edge. From the next cycle `access_o` and `stall_o` are 1 and `ser_o` shows the first step. If `shift_i` is asserted in the same cycle as the load, the load wins: no step is skipped.
- R3: While a transfer is in progress, `load_i` is refused. The word being sent is unchanged, and the refused word is never sent.
- R4: `stall_o` is 1 from the cycle after acceptance through the cycle in which the last step is shifted. It is 0 in the following cycle, and a load in that cycle is accepted.
- R5: With `lsb_first_i`=0 at acceptance, bit `size-1` of the word goes first and bit 0 goes last. Within one step, `ser_o[STEP_W-1]` carries the earliest bit.
- R6: With `lsb_first_i`=1 at acceptance, bit 0 goes first. Within one step, `ser_o[0]` carries the earliest bit.
- R7: Each `shift_i` during a transfer advances the stream by exactly `STEP_W` bits. Without `shift_i` the output holds. Changes on `size_i`, `lsb_first_i` and `data_i` during a transfer have no effect.
- R8: A transfer of `n` bits takes ceil(`n`/`STEP_W`) shifts. Step positions beyond bit `n` of the stream read 0.
- R9: A load with `size_i`=0 is ignored and the block stays idle. A `size_i` greater than `DATA_W` is treated as `DATA_W`.
- R10: In `ST_IDLE`, `ser_o` is 0 and `access_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Offer of a new word |
| data_i | input | DATA_W (8) | Parallel word |
| size_i | input | SIZE_W (4) | Number of bits to send |
| lsb_first_i | input | 1 | 1: bit 0 goes first; 0: highest valid bit goes first |
| shift_i | input | 1 | Advance the stream by one step |
| ser_o | output | STEP_W (2) | Serial bits of the current step |
| access_o | output | 1 | `ser_o` carries valid bits |
| stall_o | output | 1 | Busy; a new load will be refused |

## Verification
All three outputs come from registers one edge after the input that changes them. An accepted load, or a shift, that is driven before edge k shows up on `ser_o`, `access_o` and `stall_o` in the cycle after edge k. The bench drives inputs on the falling edge and runs a cycle-accurate model in lockstep with the design. At the next falling edge it compares all three outputs against that model. Every check, directed or random, therefore samples exactly one edge after its stimulus.

// File: rtl/pser_pkg.sv
package pser_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } pser_state_e;
endpackage

// File: rtl/pser_count.sv
module pser_count #(
    parameter int DATA_W = 8,
    parameter int STEP_W = 2,
    parameter int SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              accept_i,
    input  logic              adv_i,
    input  logic              busy_i,
    output logic [SIZE_W-1:0] eff_o,
    output logic              size_ok_o,
    output logic              last_o
);
    localparam logic [SIZE_W-1:0] MAXSZ = SIZE_W'(DATA_W);
    localparam logic [SIZE_W-1:0] STEP  = SIZE_W'(STEP_W);

    logic [SIZE_W-1:0] rem_q;

    // clamp the requested size (R9)
    always_comb begin
        eff_o     = (size_i > MAXSZ) ? MAXSZ : size_i;
        size_ok_o = (eff_o != '0);
        last_o    = (rem_q <= STEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (accept_i) begin
            rem_q <= eff_o;
        end else if (adv_i) begin
            rem_q <= last_o ? '0 : rem_q - STEP;
        end
    end

    assert_busy_has_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (rem_q != '0));
    assert_idle_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> (rem_q == '0));
endmodule

// File: rtl/pser_sreg.sv
module pser_sreg #(
    parameter int DATA_W = 8,
    parameter int STEP_W = 2,
    parameter int SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    input  logic [SIZE_W-1:0] eff_i,
    input  logic              lsb_i,
    input  logic              accept_i,
    input  logic              adv_i,
    input  logic              busy_i,
    output logic [STEP_W-1:0] ser_o
);
    logic [DATA_W-1:0] sreg_q;
    logic              lsb_q;
    logic [DATA_W-1:0] keep_mask;

    always_comb begin
        keep_mask = ~({DATA_W{1'b1}} << eff_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            lsb_q  <= 1'b0;
        end else if (accept_i) begin
            lsb_q  <= lsb_i;
            // only the low eff_i bits are sent (R5, R6, R8)
            sreg_q <= lsb_i ? (data_i & keep_mask)
                            : (data_i << (SIZE_W'(DATA_W) - eff_i));
        end else if (adv_i) begin
            sreg_q <= lsb_q ? (sreg_q >> STEP_W) : (sreg_q << STEP_W);
        end
    end

    always_comb begin
        if (!busy_i)    ser_o = '0;
        else if (lsb_q) ser_o = sreg_q[STEP_W-1:0];
        else            ser_o = sreg_q[DATA_W-1 -: STEP_W];
    end

    assert_hold_no_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !adv_i) |=> $stable(sreg_q));
    assert_drained_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> (sreg_q == '0));
endmodule

// File: rtl/pser_fsm.sv
module pser_fsm
    import pser_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic shift_i,
    input  logic size_ok_i,
    input  logic last_i,
    output logic accept_o,
    output logic adv_o,
    output logic busy_o
);
    pser_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_i && size_ok_i)  state_d = ST_SEND; // ACCEPT
            ST_SEND: if (shift_i && last_i)    state_d = ST_IDLE; // FINISH, else HOLD
            default:                           state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o   = (state_q == ST_SEND);
        accept_o = (state_q == ST_IDLE) && load_i && size_ok_i;
        adv_o    = (state_q == ST_SEND) && shift_i;
    end

    assert_stay_until_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND && !(shift_i && last_i)) |=> (state_q == ST_SEND));
    assert_refuse_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND) |-> !accept_o);
endmodule

// File: rtl/pser_shifter.sv
module pser_shifter #(
    parameter int DATA_W = 8,
    parameter int STEP_W = 2,
    parameter int SIZE_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              lsb_first_i,
    input  logic              shift_i,
    output logic [STEP_W-1:0] ser_o,
    output logic              access_o,
    output logic              stall_o
);
    logic              accept, adv, busy, size_ok, last;
    logic [SIZE_W-1:0] eff;

    pser_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .shift_i(shift_i),
        .size_ok_i(size_ok), .last_i(last),
        .accept_o(accept), .adv_o(adv), .busy_o(busy)
    );

    pser_count #(.DATA_W(DATA_W), .STEP_W(STEP_W), .SIZE_W(SIZE_W)) u_count (
        .clk(clk), .rst_n(rst_n), .size_i(size_i), .accept_i(accept),
        .adv_i(adv), .busy_i(busy), .eff_o(eff), .size_ok_o(size_ok), .last_o(last)
    );

    pser_sreg #(.DATA_W(DATA_W), .STEP_W(STEP_W), .SIZE_W(SIZE_W)) u_sreg (
        .clk(clk), .rst_n(rst_n), .data_i(data_i), .eff_i(eff), .lsb_i(lsb_first_i),
        .accept_i(accept), .adv_i(adv), .busy_i(busy), .ser_o(ser_o)
    );

    always_comb begin
        access_o = busy;
        stall_o  = busy;
    end

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_o |-> (ser_o == '0));
    assert_accept_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && load_i && size_i != '0) |=> access_o);
endmodule

// File: tb/pser_shifter_bench.sv
`timescale 1ns/1ps
module pser_shifter_bench;
    localparam int DW = 8;
    localparam int SW = 2;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [DW-1:0] data_i = '0;
    logic [CW-1:0] size_i = '0;
    logic          lsb_first_i = 1'b0;
    logic          shift_i = 1'b0;
    logic [SW-1:0] ser_o;
    logic          access_o, stall_o;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    // model state
    bit            m_busy = 1'b0;
    logic [DW-1:0] m_data = '0;
    int            m_size = 0;
    bit            m_lsb = 1'b0;
    int            m_step = 0;

    always #4 clk = ~clk;

    pser_shifter u_pser_shifter (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .data_i(data_i), .size_i(size_i),
        .lsb_first_i(lsb_first_i), .shift_i(shift_i), .ser_o(ser_o),
        .access_o(access_o), .stall_o(stall_o)
    );

    function automatic logic [SW-1:0] exp_ser(logic [DW-1:0] d, int sz, bit lsb, int st);
        logic [SW-1:0] v = '0;
        for (int i = 0; i < SW; i++) begin
            int pos;
            if (lsb) begin
                pos = st * SW + i;
                v[i] = (pos < sz) ? d[pos] : 1'b0;
            end else begin
                pos = sz - 1 - (st * SW + (SW - 1 - i));
                v[i] = (pos >= 0) ? d[pos] : 1'b0;
            end
        end
        return v;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        int e_ser = m_busy ? int'(exp_ser(m_data, m_size, m_lsb, m_step)) : 0;
        check(tag, "ser_o", int'(ser_o), e_ser);
        check(tag, "access_o", int'(access_o), int'(m_busy));
        check("R4", "stall_o", int'(stall_o), int'(m_busy));
    endtask

    // drive at the falling edge, advance the model, compare one edge later
    task automatic cyc(bit ld, logic [DW-1:0] d, int sz, bit lsb, bit sh, string tag);
        int eff;
        load_i = ld; data_i = d; size_i = CW'(sz); lsb_first_i = lsb; shift_i = sh;
        eff = (sz > DW) ? DW : sz;
        if (!m_busy) begin
            if (ld && eff != 0) begin
                m_busy = 1'b1; m_data = d; m_size = eff; m_lsb = lsb; m_step = 0;
            end
        end else if (sh) begin
            m_step++;
            if (m_step * SW >= m_size) m_busy = 1'b0;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // load and shift together: load wins
        cyc(1, 8'hA5, 8, 0, 1, "R2");
        // refused load while sending, plus holds and changed controls
        cyc(1, 8'h3C, 8, 1, 0, "R3");
        cyc(0, 8'hFF, 3, 1, 0, "R7");
        cyc(1, 8'h00, 8, 0, 1, "R3");
        cyc(0, 8'h00, 8, 0, 1, "R5");
        cyc(0, 8'h00, 8, 0, 1, "R5");
        cyc(0, 8'h00, 8, 0, 1, "R4");
        // idle right after finish: immediate load accepted
        cyc(1, 8'h96, 8, 1, 0, "R4");
        for (int k = 0; k < 4; k++) cyc(0, 8'h00, 0, 0, 1, "R6");
        // odd size, partial last step
        cyc(1, 8'hF5, 5, 0, 0, "R8");
        for (int k = 0; k < 3; k++) cyc(0, 8'h00, 0, 0, 1, "R8");
        cyc(1, 8'hEB, 3, 1, 0, "R8");
        for (int k = 0; k < 2; k++) cyc(0, 8'h00, 0, 0, 1, "R8");
        // size zero ignored, oversize clamped
        cyc(1, 8'hFF, 0, 0, 1, "R9");
        cyc(0, 8'h00, 0, 0, 0, "R10");
        cyc(1, 8'hC3, 13, 0, 0, "R9");
        for (int k = 0; k < 4; k++) cyc(0, 8'h00, 0, 0, 1, "R9");
        cyc(0, 8'h00, 0, 0, 1, "R10");

        // constrained random
        void'($urandom(32'h5EED_1234));
        for (int k = 0; k < 4000; k++) begin
            bit ld = ($urandom % 3) == 0;
            bit sh = ($urandom % 5) < 3;
            bit lb = $urandom % 2;
            int sz = $urandom % 16;
            logic [DW-1:0] d = DW'($urandom);
            string tg;
            tg = !m_busy ? "R10" : (m_lsb ? "R6" : "R5");
            cyc(ld, d, sz, lb, sh, tg);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule